// File: doc/BRIEF.md
# Transition-Density Loss-of-Signal Detector

This block watches a serial bit stream that arrives one bit per clock and decides whether the signal has gone away. A bit counts as a transition when its value differs from the bit before it. If no transition appears for a long stretch, the block raises a loss flag. While the flag is up, the forwarded data is held at zero so downstream logic sees a clean failure indication instead of noise.

Entering and leaving the loss state use different tests, which gives the flag hysteresis. Entry needs a run of more than 128 bits without any transition. Exit needs more than 16 transitions inside one fixed 128-bit window. Windows do not overlap. A window opens on the first bit after the flag rises, and a new window opens after each one that fails to clear the flag. Every counter keeps advancing on every bit clock while the flag is up. An active-low enable input switches detection off entirely. While it is off, the flag stays low and data passes through untouched.

Top module: `los_detector`

## Requirements
- R1: After reset, losFlag is 0, all counters are zero and the previous-bit reference is 0.
- R2: A bit is a transition when it differs from the previous bit. The first bit after reset is compared against 0.
- R3: losFlag rises on the clock edge that samples the 129th consecutive bit without a transition, and not earlier.
- R4: The no-transition run count restarts from zero on any transition and saturates rather than wrapping, so an arbitrarily long idle stretch never drops the flag.
- R5: bitOut equals bitIn while losFlag is 0 and is 0 while losFlag is 1, in the same cycle.
- R6: While in loss, the flag clears on the clock edge that samples the 17th transition within the current window. This also holds when that transition is the window's last bit.
- R7: Recovery windows are fixed, non-overlapping 128-bit intervals. The first window begins with the first bit after the flag rises. Transitions from one window never count toward the next.
- R8: While detEnN is 1, losFlag is 0 in the same cycle and bitOut equals bitIn. The counters are held at zero, so after detEnN returns to 0 a full 129-bit idle run is again required.
- R9: During loss, the window and run counters advance every bit clock whether or not transitions occur, and failed windows restart repeatedly without limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| bitIn | input | 1 | Incoming serial bit |
| detEnN | input | 1 | Active-low detection enable; 1 disables detection |
| bitOut | output | 1 | Forwarded bit, forced to 0 during loss |
| losFlag | output | 1 | Loss-of-signal indication |

## Verification
The embedded properties check four things on every cycle. The run count never passes its ceiling and returns to zero after a transition. The window transition tally stays within the exit threshold. The loss state holds unless an exit transition or a disable occurs. The gated output is never 1 while the flag is up. The exact edge on which the flag rises and falls can only be shown by the bench's scenarios. The same goes for the non-overlapping window boundary, the tie between the 17th transition and the end of a window, and the fresh 129-bit requirement after re-enable. The bench sweeps the idle-run length and the per-window transition count across each threshold.

// File: rtl/los_pkg.sv
package los_pkg;

  typedef enum logic {
    ST_MON  = 1'b0,
    ST_LOST = 1'b1
  } losState_t;

  typedef struct packed {
    logic runClr;
    logic winClr;
    logic winAdv;
  } losStrobe_t;

endpackage

// File: rtl/los_datapath.sv
module los_datapath
  import los_pkg::*;
#(
  parameter int RUN_LIMIT = 128,
  parameter int WIN_LEN   = 128,
  parameter int EXIT_CNT  = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitIn,
  input  logic       lostQ,
  input  losStrobe_t stb,
  output logic       trans,
  output logic       runFull,
  output logic       winEnd,
  output logic       trExceed,
  output logic       bitOut
);

  localparam int RUN_W = $clog2(RUN_LIMIT + 1);
  localparam int WIN_W = $clog2(WIN_LEN);
  localparam int TR_W  = $clog2(EXIT_CNT + 1);

  logic             prevBit;
  logic [RUN_W-1:0] runCnt;
  logic [WIN_W-1:0] winCnt;
  logic [TR_W-1:0]  trCnt;

  assign trans    = bitIn ^ prevBit;
  assign runFull  = (runCnt == RUN_W'(RUN_LIMIT));
  assign winEnd   = (winCnt == WIN_W'(WIN_LEN - 1));
  assign trExceed = trans && (trCnt == TR_W'(EXIT_CNT));
  assign bitOut   = bitIn & ~lostQ;

  always_ff @(posedge clk) begin
    if (!rstN) prevBit <= 1'b0;
    else       prevBit <= bitIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   runCnt <= '0;
    else if (stb.runClr || trans) runCnt <= '0;
    else if (!runFull)           runCnt <= runCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.winClr) begin
      winCnt <= '0;
      trCnt  <= '0;
    end else if (stb.winAdv) begin
      winCnt <= winCnt + 1'b1;
      trCnt  <= trCnt + {{(TR_W-1){1'b0}}, trans};
    end
  end

  assert_run_sat_R4: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= RUN_W'(RUN_LIMIT));

  assert_run_restart_R4: assert property (@(posedge clk) disable iff (!rstN)
    trans |=> (runCnt == '0));

  assert_tr_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    trCnt <= TR_W'(EXIT_CNT));

endmodule

// File: rtl/los_control.sv
module los_control
  import los_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       detEnN,
  input  logic       trans,
  input  logic       runFull,
  input  logic       winEnd,
  input  logic       trExceed,
  output logic       lostQ,
  output losStrobe_t stb
);

  losState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    stb    = '0;
    if (detEnN) begin
      stateD     = ST_MON;
      stb.runClr = 1'b1;
      stb.winClr = 1'b1;
    end else begin
      unique case (stateQ)
        ST_MON: begin
          if (runFull && !trans) begin
            stateD     = ST_LOST;
            stb.winClr = 1'b1;
          end
        end
        ST_LOST: begin
          if (trExceed) begin
            stateD     = ST_MON;
            stb.winClr = 1'b1;
          end else if (winEnd) begin
            stb.winClr = 1'b1;
          end else begin
            stb.winAdv = 1'b1;
          end
        end
        default: stateD = ST_MON;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_MON;
    else       stateQ <= stateD;
  end

  assign lostQ = (stateQ == ST_LOST);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_LOST && !detEnN && !trExceed) |=> (stateQ == ST_LOST));

  assert_disable_R8: assert property (@(posedge clk) disable iff (!rstN)
    detEnN |=> (stateQ == ST_MON));

endmodule

// File: rtl/los_detector.sv
module los_detector
  import los_pkg::*;
#(
  parameter int RUN_LIMIT = 128,
  parameter int WIN_LEN   = 128,
  parameter int EXIT_CNT  = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitIn,
  input  logic detEnN,
  output logic bitOut,
  output logic losFlag
);

  losStrobe_t stb;
  logic trans, runFull, winEnd, trExceed, lostQ, gatedLost;

  assign gatedLost = lostQ & ~detEnN;

  los_control u_ctrl (
    .clk(clk), .rstN(rstN), .detEnN(detEnN),
    .trans(trans), .runFull(runFull), .winEnd(winEnd), .trExceed(trExceed),
    .lostQ(lostQ), .stb(stb)
  );

  los_datapath #(
    .RUN_LIMIT(RUN_LIMIT), .WIN_LEN(WIN_LEN), .EXIT_CNT(EXIT_CNT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .lostQ(gatedLost), .stb(stb),
    .trans(trans), .runFull(runFull), .winEnd(winEnd), .trExceed(trExceed),
    .bitOut(bitOut)
  );

  assign losFlag = gatedLost;

  assert_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    losFlag |-> !bitOut);

endmodule

// File: tb/los_detector_tb_top.sv
module los_detector_tb_top;

  logic clk = 1'b0;
  logic rstN, bitIn, detEnN;
  logic bitOut, losFlag;
  logic cur;
  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  los_detector dut_i (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .detEnN(detEnN),
    .bitOut(bitOut), .losFlag(losFlag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic bitStep(input logic b);
    bitIn = b;
    cur   = b;
    @(negedge clk);
  endtask

  task automatic toggle();
    bitStep(~cur);
  endtask

  task automatic freshStart();
    detEnN = 1'b1;
    bitStep(1'b1);
    bitStep(1'b0);
    detEnN = 1'b0;
  endtask

  task automatic enterLost();
    freshStart();
    repeat (129) bitStep(1'b0);
  endtask

  task automatic finish();
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    finished = 1;
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=0 expected=1");
      finish();
    end
  end

  initial begin
    rstN = 1'b0; bitIn = 1'b1; detEnN = 1'b0; cur = 1'b0;
    repeat (3) @(negedge clk);
    check(losFlag == 1'b0, "R1 reset flag", losFlag, 0);
    check(bitOut == 1'b1, "R5 pass-through at reset", bitOut, 1);
    rstN = 1'b1;

    // R2: first bit 1 after reset is a transition; then 128 more ones stay clear
    bitStep(1'b1);
    repeat (128) bitStep(1'b1);
    check(losFlag == 1'b0, "R2 first bit transition", losFlag, 0);
    bitStep(1'b1);
    check(losFlag == 1'b1, "R2 entry after reset", losFlag, 1);

    // R3: sweep idle run length across the threshold
    for (int n = 120; n <= 132; n++) begin
      freshStart();
      repeat (n) bitStep(1'b0);
      check(losFlag == (n >= 129), "R3 entry threshold", losFlag, (n >= 129));
    end

    // R4: a transition restarts the run count
    freshStart();
    repeat (128) bitStep(1'b0);
    bitStep(1'b1);
    repeat (128) bitStep(1'b1);
    check(losFlag == 1'b0, "R4 run restart", losFlag, 0);
    bitStep(1'b1);
    check(losFlag == 1'b1, "R4 run restart entry", losFlag, 1);

    // R5: data forced low during loss
    enterLost();
    toggle();
    check(bitIn == 1'b1 && bitOut == 1'b0, "R5 gating", bitOut, 0);
    check(losFlag == 1'b1, "R5 still lost", losFlag, 1);

    // R6: sweep transitions in the first window
    for (int k = 14; k <= 18; k++) begin
      enterLost();
      repeat (k) toggle();
      repeat (128 - k) bitStep(cur);
      check(losFlag == (k < 17), "R6 exit threshold", losFlag, (k < 17));
    end

    // R6: clears exactly on the 17th transition
    enterLost();
    repeat (16) toggle();
    check(losFlag == 1'b1, "R6 after 16", losFlag, 1);
    toggle();
    check(losFlag == 1'b0, "R6 after 17", losFlag, 0);
    check(bitOut == bitIn, "R5 pass after exit", bitOut, bitIn);

    // R7: windows do not overlap
    enterLost();
    repeat (112) bitStep(cur);
    repeat (16) toggle();
    toggle();
    check(losFlag == 1'b1, "R7 window boundary", losFlag, 1);
    repeat (15) toggle();
    check(losFlag == 1'b1, "R7 second window 16", losFlag, 1);
    toggle();
    check(losFlag == 1'b0, "R7 second window 17", losFlag, 0);

    // R6: 17th transition on the last bit of a window
    enterLost();
    repeat (111) bitStep(cur);
    repeat (17) toggle();
    check(losFlag == 1'b0, "R6 exit at window end", losFlag, 0);

    // R9 / R4: long idle loss, then recovery
    enterLost();
    repeat (1000) bitStep(cur);
    check(losFlag == 1'b1, "R9 long loss holds", losFlag, 1);
    repeat (17) toggle();
    check(losFlag == 1'b0, "R9 recovery after many windows", losFlag, 0);

    // R8: disable
    enterLost();
    detEnN = 1'b1;
    bitIn = 1'b1; cur = 1'b1;
    #1;
    check(losFlag == 1'b0, "R8 immediate clear", losFlag, 0);
    check(bitOut == 1'b1, "R8 pass-through", bitOut, 1);
    @(negedge clk);
    repeat (300) bitStep(1'b1);
    check(losFlag == 1'b0, "R8 held off", losFlag, 0);
    check(bitOut == 1'b1, "R8 data passes", bitOut, 1);
    detEnN = 1'b0;
    repeat (128) bitStep(1'b1);
    check(losFlag == 1'b0, "R8 fresh run needed", losFlag, 0);
    bitStep(1'b1);
    check(losFlag == 1'b1, "R8 entry after re-enable", losFlag, 1);

    finish();
  end

endmodule